// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port

This block is a byte-addressed register port that controls six general-purpose pads. Software sets a direction mask, an output value mask and an open-drain mask through a small bus with an address, a write strobe, a read strobe and byte-wide data. Each pad gets an output value and an output enable from the block. The incoming pad levels pass through a two-stage synchronizer.

Reads of the pin view register depend on direction. An output pin returns its own latched output bit. An input pin returns its synchronized pad level. Each output pin can be push-pull or open-drain. An open-drain pin only ever pulls low, and releases the pad to let it float high.

The block has two kinds of reset and two standby modes. Power-on reset and hardware standby wipe every control register, and hardware standby also releases every pad. Manual reset and software standby preserve the registers. The bus cannot change any register while either of them is active.

Top module: `gpio6_port`

## Requirements
- R1: While `por_n` is low, and after it rises, the direction, output and open-drain registers all read as zero and every bit of `pad_oe` is 0.
- R2: A write at address 1 (output value) or address 3 (open-drain) stores `wr_data[5:0]` on the next clock edge. Reads of those addresses return the stored bits in `rd_data[5:0]`. `rd_data[7:6]` reads 0, and writes to bits 7 and 6 are dropped.
- R3: Address 0 holds the direction mask, where 1 means output. It is written like R2, but a read of address 0 always returns 0.
- R4: A read of address 2 returns the output value bit for each pin whose direction bit is 1. For each other pin it returns the pad level as sampled two clock edges earlier.
- R5: A write to address 2 changes no register.
- R6: A pin with direction 1 and open-drain 0 has `pad_oe`=1 and `pad_out` equal to its output value bit.
- R7: A pin with direction 1 and open-drain 1 has `pad_oe`=1 only while its output value bit is 0. `pad_out` is 0 whenever `pad_oe` is 1.
- R8: A pin with direction 0 has `pad_oe`=0.
- R9: While `hw_stby` is high, all of `pad_oe` is 0. At every clock edge with `hw_stby` high, all three registers clear to 0.
- R10: While `man_rst` or `sw_stby` is high, bus writes are ignored, and the registers and pad outputs keep their values.
- R11: `rd_data` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| man_rst | input | 1 | Manual reset, active high; registers are kept |
| hw_stby | input | 1 | Hardware standby, clears registers and releases pads |
| sw_stby | input | 1 | Software standby, registers are kept |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, combinational from `addr` while `rd_en` is high |
| pad_in | input | 6 | Pad input levels |
| pad_out | output | 6 | Pad output values |
| pad_oe | output | 6 | Pad output enables |

## Verification
The bench targets each of the following cases and the fault it would expose:
- **Synchronizer latency on input pins.** A design with one stage, or with three, returns the new pad level a cycle early or a cycle late.
- **Open-drain pins with the output bit set.** A design that ignores the open-drain mask drives a pad high when it should release it.
- **Retention under manual reset and software standby.** A design that treats these like power-on reset loses the registers. A design that does not block the bus lets a write through.
- **Writes to the read-only pin view address.** A design that decodes the address carelessly changes the output register on such a write.
- **Hardware standby held while software keeps writing.** A design that clears the registers but does not gate `pad_oe` leaves outputs driving for a cycle.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
  parameter int unsigned PORT_PINS   = 6;
  parameter int unsigned BUS_BITS    = 8;
  parameter int unsigned ADDR_BITS   = 2;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_VIEW = 2'd2,
    SEL_OD   = 2'd3
  } reg_sel_e;

  // Pin view: output pins show their latched value, input pins the pad.
  function automatic logic [PORT_PINS-1:0] pin_view(
    input logic [PORT_PINS-1:0] dir_m,
    input logic [PORT_PINS-1:0] out_m,
    input logic [PORT_PINS-1:0] pad_m
  );
    return (dir_m & out_m) | (~dir_m & pad_m);
  endfunction

  // Drive enable: output direction, not in hardware standby, and an
  // open-drain pin only while it pulls low.
  function automatic logic pin_enable(
    input logic dir_b,
    input logic out_b,
    input logic od_b,
    input logic stby
  );
    return dir_b & ~stby & (~od_b | ~out_b);
  endfunction
endpackage

// File: rtl/gpio6_sync.sv
module gpio6_sync #(
  parameter int unsigned WIDTH  = gpio6_pkg::PORT_PINS,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio6_regfile.sv
module gpio6_regfile #(
  parameter int unsigned NPINS  = gpio6_pkg::PORT_PINS,
  parameter int unsigned DATA_W = gpio6_pkg::BUS_BITS,
  parameter int unsigned ADDR_W = gpio6_pkg::ADDR_BITS
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              clr_all,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  od_q
);
  import gpio6_pkg::*;

  localparam logic [DATA_W-1:0] PIN_MASK = DATA_W'((1 << NPINS) - 1);

  function automatic logic [NPINS-1:0] pin_bits(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] m;
    m = d & PIN_MASK;
    return m[NPINS-1:0];
  endfunction

  logic hit_dir, hit_out, hit_od;
  assign hit_dir = wr_fire && (addr == ADDR_W'(SEL_DIR));
  assign hit_out = wr_fire && (addr == ADDR_W'(SEL_OUT));
  assign hit_od  = wr_fire && (addr == ADDR_W'(SEL_OD));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dir_q <= '0;
      out_q <= '0;
      od_q  <= '0;
    end else if (clr_all) begin
      dir_q <= '0;
      out_q <= '0;
      od_q  <= '0;
    end else begin
      if (hit_dir) dir_q <= pin_bits(wr_data);
      if (hit_out) out_q <= pin_bits(wr_data);
      if (hit_od)  od_q  <= pin_bits(wr_data);
    end
  end
endmodule

// File: rtl/gpio6_pad_drive.sv
module gpio6_pad_drive #(
  parameter int unsigned NPINS = gpio6_pkg::PORT_PINS
) (
  input  logic             stby,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] out_q,
  input  logic [NPINS-1:0] od_q,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  import gpio6_pkg::*;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pad_oe[i]  = pin_enable(dir_q[i], out_q[i], od_q[i], stby);
    assign pad_out[i] = out_q[i];
  end
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port #(
  parameter int unsigned NPINS  = gpio6_pkg::PORT_PINS,
  parameter int unsigned DATA_W = gpio6_pkg::BUS_BITS,
  parameter int unsigned ADDR_W = gpio6_pkg::ADDR_BITS
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              man_rst,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  import gpio6_pkg::*;

  localparam int unsigned RSV_W = DATA_W - NPINS;

  logic [NPINS-1:0] dir_q, out_q, od_q, pad_sync;
  logic             hold_bus;
  logic             wr_fire;
  logic [NPINS-1:0] rd_pins;

  assign hold_bus = man_rst | sw_stby | hw_stby;
  assign wr_fire  = wr_en & ~hold_bus;

  gpio6_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
    .clk    (clk),
    .por_n  (por_n),
    .d_in   (pad_in),
    .d_sync (pad_sync)
  );

  gpio6_regfile #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .por_n   (por_n),
    .clr_all (hw_stby),
    .wr_fire (wr_fire),
    .addr    (addr),
    .wr_data (wr_data),
    .dir_q   (dir_q),
    .out_q   (out_q),
    .od_q    (od_q)
  );

  gpio6_pad_drive #(.NPINS(NPINS)) u_drive (
    .stby    (hw_stby),
    .dir_q   (dir_q),
    .out_q   (out_q),
    .od_q    (od_q),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  always_comb begin
    rd_pins = '0;
    case (reg_sel_e'(addr))
      SEL_DIR:  rd_pins = '0;
      SEL_OUT:  rd_pins = out_q;
      SEL_VIEW: rd_pins = pin_view(dir_q, out_q, pad_sync);
      SEL_OD:   rd_pins = od_q;
      default:  rd_pins = '0;
    endcase
  end

  assign rd_data = rd_en ? {{RSV_W{1'b0}}, rd_pins} : '0;
endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk #(
  parameter int unsigned NPINS  = gpio6_pkg::PORT_PINS,
  parameter int unsigned DATA_W = gpio6_pkg::BUS_BITS,
  parameter int unsigned ADDR_W = gpio6_pkg::ADDR_BITS
) (
  input logic              clk,
  input logic              por_n,
  input logic              man_rst,
  input logic              hw_stby,
  input logic              sw_stby,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  out_q,
  input logic [NPINS-1:0]  od_q
);
  AST_STBY_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    hw_stby |-> (pad_oe == '0)); // R9
  AST_STBY_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    hw_stby |=> (dir_q == '0 && out_q == '0 && od_q == '0)); // R9
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!por_n)
    ((pad_oe & od_q & pad_out) == '0)); // R7
  AST_INPUT_FLOATS: assert property (@(posedge clk) disable iff (!por_n)
    ((pad_oe & ~dir_q) == '0)); // R8
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
    ((man_rst || sw_stby) && !hw_stby) |=>
      ($stable(dir_q) && $stable(out_q) && $stable(od_q))); // R10
  AST_OUT_WRITE: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && addr == ADDR_W'(1) && !man_rst && !sw_stby && !hw_stby) |=>
      (out_q == $past(wr_data[NPINS-1:0]))); // R2
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    rd_data[DATA_W-1:NPINS] == '0); // R2
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!por_n)
    !rd_en |-> (rd_data == '0)); // R11
  AST_DIR_READ_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    (addr == '0) |-> (rd_data == '0)); // R3
endmodule

bind gpio6_port gpio6_port_chk #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .por_n   (por_n),
  .man_rst (man_rst),
  .hw_stby (hw_stby),
  .sw_stby (sw_stby),
  .addr    (addr),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .dir_q   (dir_q),
  .out_q   (out_q),
  .od_q    (od_q)
);

// File: tb/gpio6_port_test.sv
`timescale 1ns/1ps
module gpio6_port_test;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       man_rst = 1'b0, hw_stby = 1'b0, sw_stby = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [5:0] pad_in = '0;
  logic [5:0] pad_out, pad_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench-side state, built from the requirements.
  logic [5:0] m_dir = '0, m_out = '0, m_od = '0, m_s1 = '0, m_s2 = '0;

  always #5 clk = ~clk;

  gpio6_port uut (
    .clk(clk), .por_n(por_n), .man_rst(man_rst), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_dir <= '0; m_out <= '0; m_od <= '0; m_s1 <= '0; m_s2 <= '0;
    end else begin
      m_s1 <= pad_in;
      m_s2 <= m_s1;
      if (hw_stby) begin
        m_dir <= '0; m_out <= '0; m_od <= '0;
      end else if (wr_en && !man_rst && !sw_stby) begin
        case (addr)
          2'd0: m_dir <= wr_data[5:0];
          2'd1: m_out <= wr_data[5:0];
          2'd3: m_od  <= wr_data[5:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_read();
    logic [5:0] v;
    if (!rd_en) return 8'h00;
    case (addr)
      2'd1: v = m_out;
      2'd2: for (int i = 0; i < 6; i++) v[i] = m_dir[i] ? m_out[i] : m_s2[i];
      2'd3: v = m_od;
      default: v = '0;
    endcase
    return {2'b00, v};
  endfunction

  function automatic logic [5:0] exp_oe();
    logic [5:0] e;
    for (int i = 0; i < 6; i++)
      e[i] = !hw_stby && m_dir[i] && (!m_od[i] || (m_out[i] == 1'b0));
    return e;
  endfunction

  function automatic string read_tag();
    if (!rd_en) return "R11";
    case (addr)
      2'd0: return "R3";
      2'd2: return "R4";
      default: return "R2";
    endcase
  endfunction

  function automatic string oe_tag();
    if (hw_stby) return "R9";
    if (m_od != 0) return "R7";
    if (m_dir != 6'h3f) return "R8";
    return "R6";
  endfunction

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    string t;
    #1;
    t = (tag == "") ? read_tag() : tag;
    cmp(t, rd_data, exp_read());
    t = (tag == "") ? oe_tag() : tag;
    cmp(t, {2'b00, pad_oe}, {2'b00, exp_oe()});
    cmp((tag == "") ? "R6" : tag, {2'b00, pad_out}, {2'b00, m_out});
  endtask

  task automatic bus(input logic w, input logic r, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wr_data = d;
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    bus(1'b0, 1'b1, a, 8'h00);
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: reset state
    repeat (2) @(negedge clk);
    rd_en = 1'b1; addr = 2'd1; #1; cmp("R1", rd_data, 8'h00); cmp("R1", {2'b00, pad_oe}, 8'h00);
    @(negedge clk); por_n = 1'b1;
    rd(2'd1, "R1"); rd(2'd3, "R1"); rd(2'd0, "R1");

    // R2 / R3: register writes with reserved bits set
    bus(1'b1, 1'b0, 2'd1, 8'hEA);
    bus(1'b1, 1'b0, 2'd3, 8'hC5);
    bus(1'b1, 1'b0, 2'd0, 8'hFF);
    rd(2'd1, "R2"); cmp("R2", rd_data, 8'h2A);
    rd(2'd3, "R2"); cmp("R2", rd_data, 8'h05);
    rd(2'd0, "R3"); cmp("R3", rd_data, 8'h00);
    // R6 / R7: mixed push-pull and open-drain on all-output pins
    check_all("R7");

    // R5: write to pin view address changes nothing
    bus(1'b1, 1'b0, 2'd2, 8'h11);
    rd(2'd1, "R5"); cmp("R5", rd_data, 8'h2A);
    rd(2'd3, "R5"); cmp("R5", rd_data, 8'h05);

    // R4: synchronizer latency on input pins
    bus(1'b1, 1'b0, 2'd0, 8'h00);
    pad_in = 6'h00;
    repeat (3) rd(2'd2, "R4");
    @(negedge clk); pad_in = 6'h15; rd_en = 1'b1; addr = 2'd2; wr_en = 1'b0;
    #1; cmp("R4", rd_data, 8'h00);
    @(negedge clk); #1; cmp("R4", rd_data, 8'h00);
    @(negedge clk); #1; cmp("R4", rd_data, 8'h15);
    // mixed direction: pins 5..3 output
    bus(1'b1, 1'b0, 2'd0, 8'h38);
    rd(2'd2, "R4"); cmp("R4", rd_data, {2'b00, 3'b101, 3'b101});

    // R10: manual reset and software standby hold everything
    @(negedge clk); man_rst = 1'b1;
    bus(1'b1, 1'b0, 2'd1, 8'h3F);
    bus(1'b1, 1'b0, 2'd3, 8'h00);
    rd(2'd1, "R10"); cmp("R10", rd_data, 8'h2A);
    @(negedge clk); man_rst = 1'b0; sw_stby = 1'b1;
    bus(1'b1, 1'b0, 2'd0, 8'h00);
    rd(2'd3, "R10"); cmp("R10", rd_data, 8'h05);
    check_all("R10");
    @(negedge clk); sw_stby = 1'b0;

    // R9: hardware standby gates enables at once and clears registers
    @(negedge clk); hw_stby = 1'b1; #1; cmp("R9", {2'b00, pad_oe}, 8'h00);
    bus(1'b1, 1'b0, 2'd1, 8'h3F);
    rd(2'd1, "R9"); cmp("R9", rd_data, 8'h00);
    @(negedge clk); hw_stby = 1'b0;
    rd(2'd3, "R9");

    // R8: all inputs, nothing driven
    bus(1'b1, 1'b0, 2'd1, 8'h3F);
    bus(1'b1, 1'b0, 2'd0, 8'h00);
    check_all("R8");

    // Constrained random traffic
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      man_rst = ($urandom_range(0, 15) == 0);
      sw_stby = ($urandom_range(0, 15) == 0);
      hw_stby = ($urandom_range(0, 23) == 0);
      wr_en   = ($urandom_range(0, 2) == 0);
      rd_en   = ($urandom_range(0, 3) != 0);
      addr    = 2'($urandom_range(0, 3));
      wr_data = 8'($urandom);
      if ($urandom_range(0, 3) == 0) pad_in = 6'($urandom);
      check_all("");
    end
    @(negedge clk);
    man_rst = 1'b0; sw_stby = 1'b0; hw_stby = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule